// File: doc/BRIEF.md
# Counted Test-Pattern Error Injector

This block sits on the byte stream leaving a test-pattern generator and deliberately corrupts a programmed number of outgoing test bytes. It is used to confirm that a far-end pattern checker detects and counts errors. A processor write loads an 8-bit injection count, and that write also starts injection.

From that point, each time slot that carries test data and lies inside the selected slot range has bit 0 of its byte inverted. Only one error is placed in any one slot. This continues until the count is used up. The block then raises a sticky completion flag and gives a one-cycle pulse that clears the test command register.

The data path has no registers: a corrupted byte leaves in the same cycle it arrives. The counter and the status are registered.

Top module: `errinj_top`

## Requirements
- R1: After reset, `out_data` equals `gen_data`, and `done_sts` and `cmd_clr` are 0.
- R2: A cycle with `cnt_wr`=1 and a nonzero `cnt_wdata` arms injection. Corruption starts with qualifying slots in the cycles after the write. A slot in the write cycle itself is judged on the count that was held before the write.
- R3: A corrupted byte differs from `gen_data` only in bit 0, which is inverted (mask 0x01). The change shows in the same cycle as the slot.
- R4: Only cycles with `slot_vld`=1 and `slot_in_rng`=1 are corrupted or use up count. Other cycles pass data through unchanged and leave the count as it was.
- R5: For a count of N, exactly the next N qualifying slots are corrupted, one error per slot, and later slots pass through unchanged.
- R6: `done_sts` goes to 1 in the cycle after the slot that carries the last error, and stays at 1 until it is read.
- R7: `cmd_clr` is a pulse exactly one cycle long. It rises together with the setting of `done_sts`.
- R8: Writing a count of 0 corrupts nothing and never sets `done_sts`.
- R9: A cycle with `done_rd`=1 clears `done_sts` in the next cycle. If a completion happens in the same cycle, the set wins.
- R10: A count written while injection is in progress replaces the remaining count. The errors that follow equal the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_data | input | 8 | Byte from the pattern generator |
| slot_vld | input | 1 | This cycle carries a time slot |
| slot_in_rng | input | 1 | The slot lies in the test range |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Injection count being written |
| done_rd | input | 1 | Status read; clears the done flag |
| out_data | output | 8 | Outgoing byte, possibly corrupted |
| done_sts | output | 1 | Sticky injection-complete flag |
| cmd_clr | output | 1 | One-cycle command-register clear |

## Verification
The hardest situation to reach is a count rewrite that lands while errors are still outstanding. It is made harder when the write cycle also carries a qualifying slot, because the old count still governs that slot. The bench arms a count of 5 and lets two errors through. It then rewrites the count to 1 in a cycle that has a live in-range slot, and checks that slot as well as the single error that follows. It also steps through idle and out-of-range slots placed between qualifying ones, to show that they neither corrupt data nor use up count.

// File: rtl/errinj_pkg.sv
package errinj_pkg;
  typedef enum logic [1:0] {CNT_HOLD, CNT_LOAD, CNT_DEC} cnt_op_e;

  // A write takes priority over a decrement in the same cycle.
  function automatic cnt_op_e pick_op(input logic wr, input logic fire);
    if (wr)        return CNT_LOAD;
    else if (fire) return CNT_DEC;
    else           return CNT_HOLD;
  endfunction

  // Next done flag: a completion beats a clearing read.
  function automatic logic next_done(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/errinj_counter.sv
module errinj_counter
  import errinj_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             slot_hit,
  output logic             inj_fire,
  output logic             inj_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;
  cnt_op_e          op;

  assign inj_fire = slot_hit && (remaining != '0);
  assign inj_last = inj_fire && (remaining == ONE) && !cnt_wr;
  assign op       = pick_op(cnt_wr, inj_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else begin
      case (op)
        CNT_LOAD: remaining <= cnt_wdata;
        CNT_DEC:  remaining <= remaining - ONE;
        default:  remaining <= remaining;
      endcase
    end
  end
endmodule

// File: rtl/errinj_flip.sv
module errinj_flip #(
  parameter int DATA_W   = 8,
  parameter int FLIP_BIT = 0
) (
  input  logic [DATA_W-1:0] gen_data,
  input  logic              inj_fire,
  output logic [DATA_W-1:0] out_data
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == FLIP_BIT) begin : g_flip
      assign out_data[i] = gen_data[i] ^ inj_fire;
    end else begin : g_pass
      assign out_data[i] = gen_data[i];
    end
  end
endmodule

// File: rtl/errinj_status.sv
module errinj_status
  import errinj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inj_last,
  input  logic done_rd,
  output logic done_sts,
  output logic cmd_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_sts <= 1'b0;
      cmd_clr  <= 1'b0;
    end else begin
      done_sts <= next_done(done_sts, inj_last, done_rd);
      cmd_clr  <= inj_last;
    end
  end
endmodule

// File: rtl/errinj_top.sv
module errinj_top #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int FLIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] gen_data,
  input  logic              slot_vld,
  input  logic              slot_in_rng,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              done_rd,
  output logic [DATA_W-1:0] out_data,
  output logic              done_sts,
  output logic              cmd_clr
);
  logic slot_hit;
  logic inj_fire;
  logic inj_last;

  assign slot_hit = slot_vld && slot_in_rng;

  errinj_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .slot_hit(slot_hit), .inj_fire(inj_fire), .inj_last(inj_last)
  );

  errinj_flip #(.DATA_W(DATA_W), .FLIP_BIT(FLIP_BIT)) u_flip (
    .gen_data(gen_data), .inj_fire(inj_fire), .out_data(out_data)
  );

  errinj_status u_sts (
    .clk(clk), .rst_n(rst_n), .inj_last(inj_last), .done_rd(done_rd),
    .done_sts(done_sts), .cmd_clr(cmd_clr)
  );
endmodule

// File: rtl/errinj_chk.sv
module errinj_chk #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int FLIP_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] gen_data,
  input logic              slot_vld,
  input logic              slot_in_rng,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              done_rd,
  input logic [DATA_W-1:0] out_data,
  input logic              done_sts,
  input logic              cmd_clr,
  input logic              inj_fire,
  input logic              inj_last
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(1) << FLIP_BIT;

  AST_ONLY_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_data ^ gen_data) & ~MASK) == '0); // R3
  AST_NO_FLIP_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_vld && slot_in_rng) |-> out_data == gen_data); // R4
  AST_FIRE_MEANS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> (out_data ^ gen_data) == MASK); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    inj_last |=> done_sts && cmd_clr); // R6
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !cmd_clr); // R7
  AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |-> done_sts); // R7
  AST_ZERO_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wdata == '0) |=> out_data == gen_data); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd && !inj_last) |=> !done_sts); // R9
endmodule

bind errinj_top errinj_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FLIP_BIT(FLIP_BIT)) u_chk (.*);

// File: tb/test_errinj_top.sv
`timescale 1ns/1ps
module test_errinj_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] gen_data;
  logic       slot_vld, slot_in_rng, cnt_wr, done_rd;
  logic [7:0] cnt_wdata;
  logic [7:0] out_data;
  logic       done_sts, cmd_clr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  errinj_top i_errinj_top (
    .clk(clk), .rst_n(rst_n), .gen_data(gen_data), .slot_vld(slot_vld),
    .slot_in_rng(slot_in_rng), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .done_rd(done_rd), .out_data(out_data), .done_sts(done_sts), .cmd_clr(cmd_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    gen_data = 8'h00; slot_vld = 0; slot_in_rng = 0;
    cnt_wr = 0; cnt_wdata = 8'h00; done_rd = 0;
  endtask

  // One cycle: drive after negedge, sample 1 ns later, advance to next negedge.
  task automatic cyc(input logic [7:0] d, input logic v, input logic r,
                     input logic wr, input logic [7:0] wd, input logic rd,
                     output logic [7:0] o);
    gen_data = d; slot_vld = v; slot_in_rng = r;
    cnt_wr = wr; cnt_wdata = wd; done_rd = rd;
    #1 o = out_data;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_done();
    logic [7:0] o;
    cyc(8'h00, 0, 0, 0, 8'h00, 1, o);
  endtask

  task automatic t_reset();
    idle_inputs();
    gen_data = 8'h3C; slot_vld = 1; slot_in_rng = 1;
    #1;
    check("R1 out passthrough", out_data, 8'h3C);
    check("R1 done", done_sts, 0);
    check("R1 cmd_clr", cmd_clr, 0);
    idle_inputs();
  endtask

  task automatic t_basic();
    logic [7:0] o;
    cyc(8'h00, 0, 0, 1, 8'd3, 0, o);
    for (int k = 0; k < 3; k++) begin
      cyc(8'hA5, 1, 1, 0, 0, 0, o);
      check("R3 R5 flipped slot", o, 8'hA4);
    end
    #1;
    check("R6 done after last", done_sts, 1);
    check("R7 cmd_clr pulse", cmd_clr, 1);
    cyc(8'hA5, 1, 1, 0, 0, 0, o);
    check("R5 no extra flip", o, 8'hA5);
    #1;
    check("R7 cmd_clr one cycle", cmd_clr, 0);
    check("R6 done sticky", done_sts, 1);
    cyc(8'h5A, 1, 1, 0, 0, 0, o);
    check("R5 no extra flip 2", o, 8'h5A);
  endtask

  task automatic t_read_clear();
    #1;
    check("R9 done before read", done_sts, 1);
    clear_done();
    #1;
    check("R9 done cleared by read", done_sts, 0);
  endtask

  task automatic t_qualify();
    logic [7:0] o;
    cyc(8'h00, 0, 0, 1, 8'd2, 0, o);
    cyc(8'h11, 1, 0, 0, 0, 0, o); check("R4 out-of-range untouched", o, 8'h11);
    cyc(8'h22, 0, 1, 0, 0, 0, o); check("R4 invalid untouched", o, 8'h22);
    cyc(8'h33, 1, 1, 0, 0, 0, o); check("R2 R4 first hit flips", o, 8'h32);
    cyc(8'h44, 1, 0, 0, 0, 0, o); check("R4 gap untouched", o, 8'h44);
    #1; check("R6 not done yet", done_sts, 0);
    cyc(8'h55, 1, 1, 0, 0, 0, o); check("R5 second hit flips", o, 8'h54);
    cyc(8'h66, 1, 1, 0, 0, 0, o); check("R5 count used up", o, 8'h66);
    clear_done();
  endtask

  task automatic t_zero();
    logic [7:0] o;
    cyc(8'h00, 0, 0, 1, 8'd0, 0, o);
    for (int k = 0; k < 3; k++) begin
      cyc(8'hF0, 1, 1, 0, 0, 0, o);
      check("R8 zero count no flip", o, 8'hF0);
    end
    #1;
    check("R8 zero count no done", done_sts, 0);
    check("R8 zero count no cmd_clr", cmd_clr, 0);
  endtask

  task automatic t_rewrite();
    logic [7:0] o;
    cyc(8'h00, 0, 0, 1, 8'd5, 0, o);
    cyc(8'h81, 1, 1, 0, 0, 0, o); check("R10 pre-rewrite flip 1", o, 8'h80);
    cyc(8'h82, 1, 1, 0, 0, 0, o); check("R10 pre-rewrite flip 2", o, 8'h83);
    // rewrite with a live slot: old count still governs this slot
    cyc(8'h84, 1, 1, 1, 8'd1, 0, o); check("R2 R10 write-cycle slot uses old count", o, 8'h85);
    #1; check("R10 no done at rewrite", done_sts, 0);
    cyc(8'h86, 1, 1, 0, 0, 0, o); check("R10 new count flip", o, 8'h87);
    #1; check("R10 R6 done after new count", done_sts, 1);
    cyc(8'h88, 1, 1, 0, 0, 0, o); check("R10 remaining replaced", o, 8'h88);
  endtask

  task automatic t_set_wins();
    logic [7:0] o;
    // done is 1 here; arm count 1, then read in the completion cycle
    cyc(8'h00, 0, 0, 1, 8'd1, 0, o);
    cyc(8'h0F, 1, 1, 0, 0, 1, o); check("R3 flip with read", o, 8'h0E);
    #1;
    check("R9 set wins over read", done_sts, 1);
    check("R7 pulse on set-wins", cmd_clr, 1);
    clear_done();
    #1; check("R9 later read clears", done_sts, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_basic();
    t_read_clear();
    t_qualify();
    t_zero();
    t_rewrite();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule